// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block guards a processor against runaway software. A counter advances once per machine cycle (the surrounding chip asserts a one-cycle enable every twelve oscillator periods) and, unless software services it in time, the block raises a one-cycle reset request to the system reset sequencer. The block cannot be switched off while the clock runs. The only way to hold off the reset is to restart the count.

Servicing is done through a write-only byte register. The count restarts only when the byte 0x1E is written and the very next write carries 0xE1. Any other write order leaves the count untouched. Cycles with no write between the two key bytes do not break the sequence. In idle mode the count keeps running, so software has to wake up to service it. In power-down mode the count is frozen and holds its value.

Top module: `keyed_watchdog`

## Requirements
- R1: While `rst` is high, `rst_req` is 0 and the count is cleared. After `rst` falls, the first `rst_req` pulse follows the 16383rd machine-cycle tick, counted from the first edge with `rst` low.
- R2: A tick is a clock edge with `mc_en` high and `pdown` low. Edges with `mc_en` low do not advance the count.
- R3: A write of 0x1E followed by a write of 0xE1 as the next write restarts the count at the edge of the 0xE1 write. A tick in that same cycle is not counted. The next pulse follows the 16383rd tick after that edge.
- R4: The bytes in reversed order (0xE1, then 0xE1's partner 0x1E) do not restart the count.
- R5: After 0x1E, a write of any byte other than 0xE1 drops the armed state without restarting the count. This includes a second 0x1E, so 0x1E, 0x1E, 0xE1 does not restart. Cycles with `wr_en` low between the two key bytes do not drop the armed state.
- R6: `rst_req` is high for exactly one clock cycle. The count restarts from zero, so the next pulse follows another 16383 ticks.
- R7: The `idle` input has no effect on counting or on the pulse timing.
- R8: While `pdown` is high, the count holds its value and no pulse is raised. Counting resumes where it stopped once `pdown` falls.
- R9: A completed key sequence whose 0xE1 write lands on the tick that would reach terminal count restarts the count, and no pulse is raised.
- R10: No stream of writes other than the exact key pair affects the count or disables the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-derived clock |
| rst | input | 1 | Synchronous active-high system reset |
| mc_en | input | 1 | One-cycle machine-cycle enable |
| wr_en | input | 1 | Write strobe for the service register |
| wr_data | input | 8 | Byte written to the service register |
| idle | input | 1 | Processor is in idle mode |
| pdown | input | 1 | Processor is in power-down mode |
| rst_req | output | 1 | One-cycle reset request to the reset sequencer |

## Verification
The hardest situation to reach is a key sequence that completes on the very tick that would hit terminal count, because it needs 16382 ticks of setup and a precisely placed write pair. The bench steps the count to one short of terminal and writes the first key on a cycle with no tick. It then writes the second key together with a tick. The other cases follow the same plan: reversed and broken sequences, power-down pauses and idle stretches are each placed at known tick counts. In each case the exact pulse cycle is predicted, followed by a random phase checked against a bench model.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    KEY_WAIT_FIRST  = 1'b0,
    KEY_WAIT_SECOND = 1'b1
  } key_state_t;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2
  } pwr_mode_t;
endpackage

// File: rtl/wdt_pwr_decode.sv
module wdt_pwr_decode
  import wdt_pkg::*;
(
  input  logic      mc_en,
  input  logic      idle,
  input  logic      pdown,
  output pwr_mode_t mode_o,
  output logic      count_en_o
);
  // Power-down dominates idle; idle keeps the count running.
  always_comb begin
    if (pdown)     mode_o = PM_DOWN;
    else if (idle) mode_o = PM_IDLE;
    else           mode_o = PM_RUN;
  end

  assign count_en_o = mc_en && (mode_o != PM_DOWN);
endmodule

// File: rtl/wdt_key_check.sv
module wdt_key_check
  import wdt_pkg::*;
#(
  parameter int          KEY_W      = 8,
  parameter logic [KEY_W-1:0] FIRST_KEY  = 8'h1E,
  parameter logic [KEY_W-1:0] SECOND_KEY = 8'hE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_data,
  output logic             service_o
);
  key_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr_en) begin
      // Every write either arms (first key from rest) or returns to rest.
      if (state_q == KEY_WAIT_FIRST && wr_data == FIRST_KEY)
        state_d = KEY_WAIT_SECOND;
      else
        state_d = KEY_WAIT_FIRST;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= KEY_WAIT_FIRST;
    else     state_q <= state_d;
  end

  assign service_o = wr_en && (state_q == KEY_WAIT_SECOND) && (wr_data == SECOND_KEY);
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             count_en,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] LAST = {{(CNT_W-1){1'b1}}, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o    <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (clear) begin
        cnt_o <= '0;
      end else if (count_en) begin
        if (cnt_o == LAST) begin
          // This tick reaches the all-ones terminal value.
          cnt_o    <= '0;
          expire_o <= 1'b1;
        end else begin
          cnt_o <= cnt_o + ONE;
        end
      end
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int          CNT_W      = 14,
  parameter int          KEY_W      = 8,
  parameter logic [KEY_W-1:0] FIRST_KEY  = 8'h1E,
  parameter logic [KEY_W-1:0] SECOND_KEY = 8'hE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mc_en,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_data,
  input  logic             idle,
  input  logic             pdown,
  output logic             rst_req
);
  pwr_mode_t        mode;
  logic             count_en;
  logic             service;
  logic [CNT_W-1:0] count_q;
  logic             expire;

  wdt_pwr_decode u_pwr (
    .mc_en      (mc_en),
    .idle       (idle),
    .pdown      (pdown),
    .mode_o     (mode),
    .count_en_o (count_en)
  );

  wdt_key_check #(
    .KEY_W      (KEY_W),
    .FIRST_KEY  (FIRST_KEY),
    .SECOND_KEY (SECOND_KEY)
  ) u_key (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .service_o (service)
  );

  wdt_tick_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .count_en (count_en),
    .clear    (service),
    .cnt_o    (count_q),
    .expire_o (expire)
  );

  assign rst_req = expire;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int          CNT_W      = 14,
  parameter int          KEY_W      = 8,
  parameter logic [KEY_W-1:0] SECOND_KEY = 8'hE1
) (
  input logic             clk,
  input logic             rst,
  input logic             mc_en,
  input logic             wr_en,
  input logic [KEY_W-1:0] wr_data,
  input logic             pdown,
  input logic             rst_req,
  input logic             service,
  input logic [CNT_W-1:0] cnt
);
  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    service |=> (cnt == '0));

  assert_wrong_byte_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data != SECOND_KEY) |-> !service);

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (cnt == '0));

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (!mc_en && !service) |=> $stable(cnt));

  assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    (pdown && !service) |=> $stable(cnt));

  assert_no_pulse_down_R8: assert property (@(posedge clk) disable iff (rst)
    pdown |=> !rst_req);
endmodule

bind keyed_watchdog wdt_checker #(
  .CNT_W      (CNT_W),
  .KEY_W      (KEY_W),
  .SECOND_KEY (SECOND_KEY)
) u_wdt_chk (
  .clk     (clk),
  .rst     (rst),
  .mc_en   (mc_en),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .pdown   (pdown),
  .rst_req (rst_req),
  .service (service),
  .cnt     (count_q)
);

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;
  localparam int TERM = 16383;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mc_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       idle = 1'b0;
  logic       pdown = 1'b0;
  logic       rst_req;

  int checks = 0;
  int fails = 0;
  int dut_pulses = 0;
  int m_pulses = 0;
  int m_cnt = 0;
  bit m_armed = 1'b0;
  bit m_req = 1'b0;
  bit done = 1'b0;
  string cur_tag = "R1";

  keyed_watchdog dut (
    .clk(clk), .rst(rst), .mc_en(mc_en), .wr_en(wr_en),
    .wr_data(wr_data), .idle(idle), .pdown(pdown), .rst_req(rst_req)
  );

  always #5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model built from the requirements.
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_armed = 1'b0; m_req = 1'b0;
    end else begin
      bit svc;
      svc = wr_en && m_armed && (wr_data == 8'hE1);
      if (wr_en) m_armed = !m_armed && (wr_data == 8'h1E);
      m_req = 1'b0;
      if (svc) m_cnt = 0;
      else if (mc_en && !pdown) begin
        if (m_cnt == TERM - 1) begin
          m_cnt = 0; m_req = 1'b1; m_pulses++;
        end else m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && (m_req || rst_req)) chk(cur_tag, int'(rst_req), int'(m_req));
    if (rst_req) dut_pulses++;
  end

  task automatic cyc(bit me, bit we, logic [7:0] d);
    mc_en = me; wr_en = we; wr_data = d;
    @(negedge clk); #1;
  endtask

  task automatic ticks(int n);
    repeat (n) cyc(1'b1, 1'b0, 8'h00);
  endtask

  task automatic expect_pulse(string tag);
    cyc(1'b1, 1'b0, 8'h00);
    chk({tag, " pulse at terminal"}, int'(rst_req), 1);
    cyc(1'b0, 1'b0, 8'h00);
    chk("R6 pulse one cycle", int'(rst_req), 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int snap;
    void'($urandom(32'd20240607));
    @(negedge clk); #1;
    repeat (3) cyc(1'b1, 1'b0, 8'h00);
    chk("R1 reset output", int'(rst_req), 0);
    rst = 1'b0;

    // R1: first timeout from reset
    cur_tag = "R1";
    ticks(TERM - 1);
    chk("R1 no pulse before terminal", dut_pulses, 0);
    expect_pulse("R1");

    // R6/R7: restart from zero, idle keeps counting
    cur_tag = "R7"; idle = 1'b1;
    snap = dut_pulses;
    ticks(TERM - 1);
    chk("R7 no early pulse in idle", dut_pulses, snap);
    expect_pulse("R6 R7");
    idle = 1'b0;

    // R3: correct sequence with gap cycles restarts count
    cur_tag = "R3";
    ticks(10000);
    cyc(1'b0, 1'b1, 8'h1E);
    cyc(1'b0, 1'b0, 8'h00);
    cyc(1'b0, 1'b0, 8'h00);
    cyc(1'b1, 1'b1, 8'hE1);
    snap = dut_pulses;
    ticks(TERM - 1);
    chk("R3 count restarted", dut_pulses, snap);
    expect_pulse("R3");

    // R4/R5: reversed and broken sequences do not restart
    cur_tag = "R4";
    ticks(100);
    cyc(1'b1, 1'b1, 8'hE1); cyc(1'b1, 1'b1, 8'h1E);
    cyc(1'b1, 1'b1, 8'h55);
    cyc(1'b1, 1'b1, 8'h1E); cyc(1'b1, 1'b1, 8'h55); cyc(1'b1, 1'b1, 8'hE1);
    cyc(1'b1, 1'b1, 8'h1E); cyc(1'b1, 1'b1, 8'h1E); cyc(1'b1, 1'b1, 8'hE1);
    snap = dut_pulses;
    ticks(TERM - 1 - 109);
    chk("R5 no early pulse", dut_pulses, snap);
    expect_pulse("R4 R5");

    // R8/R2: power-down freeze and idle enable
    cur_tag = "R8";
    ticks(16000);
    pdown = 1'b1;
    repeat (500) cyc(1'b1, 1'b0, 8'h00);
    chk("R8 no pulse in power-down", int'(rst_req), 0);
    pdown = 1'b0;
    repeat (200) cyc(1'b0, 1'b0, 8'h00);
    snap = dut_pulses;
    ticks(TERM - 1 - 16000);
    chk("R8 R2 frozen ticks not counted", dut_pulses, snap);
    expect_pulse("R8");

    // R9: service lands on the terminal tick
    cur_tag = "R9";
    ticks(TERM - 1);
    cyc(1'b0, 1'b1, 8'h1E);
    cyc(1'b1, 1'b1, 8'hE1);
    chk("R9 service beats terminal", int'(rst_req), 0);
    snap = dut_pulses;
    ticks(TERM - 1);
    chk("R9 restarted", dut_pulses, snap);
    expect_pulse("R9");

    // R10: random writes and enables against the model
    cur_tag = "R10";
    for (int i = 0; i < 20000; i++) begin
      int r;
      logic [7:0] d;
      r = $urandom % 3;
      d = (r == 0) ? 8'h1E : (r == 1) ? 8'hE1 : 8'($urandom);
      idle  = ($urandom % 4) == 0;
      pdown = ($urandom % 20) == 0;
      cyc(($urandom % 10) < 7, ($urandom % 50) == 0, d);
    end
    pdown = 1'b0;
    chk("R10 pulse count vs model", dut_pulses, m_pulses);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule